// File: doc/BRIEF.md
# Packed Lane Conditional Move Unit

This unit executes one group of SIMD instructions: conditional moves that work on packed lanes. It receives a 32-bit instruction word on a valid/ready handshake. It first checks whether the word belongs to its group. It then reads three operands from a local file of sixteen 32-bit registers: a condition register, a source register and the destination register. Each lane of the destination is either replaced by the matching source lane or left as it was. The choice depends on whether the matching condition lane is zero.

There are six sub-operations. Each one is a "zero" or "nonzero" test applied at one of three lane widths: byte, halfword or full word. All six share a single group code. Lanes are decided independently, so the old destination value is always read as well as written. The register write happens on the accepting clock edge. A one-cycle completion strobe follows, together with two flags: one says the word was not claimed, the other marks a reserved sub-operation. A side port lets a test environment load and inspect any register while no instruction is being issued.

Top module: `pcmove_unit`

## Requirements
- R1: A word whose bits [5:0] differ from 0x39 is not claimed. One cycle after acceptance, `done` and `not_claimed` are both 1, and no register changes.
- R2: A claimed word with sub-operation bits [20:18] equal to 6 or 7 sets `rsvd_flag` together with `done` and changes no register. `not_claimed` and `rsvd_flag` are never high at the same time.
- R3: Byte mode uses sub-operation 0 (move if zero) and 1 (move if nonzero). Each of the four bytes of the destination takes the source byte when the condition byte passes its own test. Otherwise the byte keeps its old value.
- R4: Halfword mode uses sub-operation 2 (move if zero) and 3 (move if nonzero). The same rule applies separately to bits [31:16] and bits [15:0], and each half is tested on its own 16-bit condition lane.
- R5: Word mode uses sub-operation 4 (move if zero) and 5 (move if nonzero). The whole 32-bit condition is tested. The destination becomes the source when the test passes and is left untouched when it fails.
- R6: The destination index is taken from bits [9:6], the condition index from bits [13:10] and the source index from bits [17:14]. Only the destination register can change.
- R7: When the condition index equals the destination index, the test uses the register value from before the update.
- R8: `insn_ready` is low while `side_we` is high and high otherwise. `done` is high exactly in the cycle after an accepted instruction and low in every other cycle.
- R9: Reset clears all registers to zero. A side write with `side_we` stores `side_wdata` at `side_addr`. `side_rdata` always shows the register at `side_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit can accept an instruction |
| insn_word | input | 32 | Instruction word |
| done | output | 1 | Completion strobe, one cycle after acceptance |
| not_claimed | output | 1 | Accepted word was outside the group (valid with done) |
| rsvd_flag | output | 1 | Accepted word used a reserved sub-operation (valid with done) |
| side_we | input | 1 | Side-port register write enable |
| side_addr | input | 4 | Side-port register index |
| side_wdata | input | 32 | Side-port write data |
| side_rdata | output | 32 | Side-port read data |

## Verification
The bench builds the unit with its default parameters: sixteen 32-bit registers and group code 0x39. These values match the instruction field layout, so every index field and every sub-operation code can be reached directly. With four bytes per word, the bench can place condition patterns where only some bytes or only one halfword are zero, and so expose any leaking between lanes. Because there are only sixteen registers, the whole file is read back after each instruction. This confirms that only the destination changed, including the case where the condition and destination registers are the same.

// File: rtl/pcmove_unit.sv
module pcmove_unit #(
  parameter int NREGS = 16,
  parameter int XLEN = 32,
  parameter logic [5:0] GROUP_OP = 6'h39
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     insn_valid,
  output logic                     insn_ready,
  input  logic [31:0]              insn_word,
  output logic                     done,
  output logic                     not_claimed,
  output logic                     rsvd_flag,
  input  logic                     side_we,
  input  logic [$clog2(NREGS)-1:0] side_addr,
  input  logic [XLEN-1:0]          side_wdata,
  output logic [XLEN-1:0]          side_rdata
);
  localparam int IDXW = $clog2(NREGS);
  localparam int NB = XLEN / 8;

  logic [XLEN-1:0] rf [NREGS];

  wire accept = insn_valid && insn_ready;
  wire [2:0] sub = insn_word[20:18];
  wire [IDXW-1:0] rd_i = insn_word[6 +: IDXW];
  wire [IDXW-1:0] rc_i = insn_word[10 +: IDXW];
  wire [IDXW-1:0] rs_i = insn_word[14 +: IDXW];
  wire claimed = insn_word[5:0] == GROUP_OP;
  wire legal = claimed && (sub < 3'd6);

  wire [XLEN-1:0] cond = rf[rc_i];
  wire [XLEN-1:0] src  = rf[rs_i];
  wire [XLEN-1:0] dst  = rf[rd_i];

  logic [NB-1:0] bz, hz, zmask, mask;
  logic [XLEN-1:0] merged;
  wire wz = &bz;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign bz[g] = cond[8*g +: 8] == 8'd0;
    assign hz[g] = bz[g & ~1] & bz[g | 1];
    assign merged[8*g +: 8] = mask[g] ? src[8*g +: 8] : dst[8*g +: 8];
  end

  always_comb begin
    case (sub[2:1])
      2'd0:    zmask = bz;
      2'd1:    zmask = hz;
      default: zmask = {NB{wz}};
    endcase
    mask = sub[0] ? ~zmask : zmask;
  end

  wire wr_en = accept && legal && (|mask);

  assign insn_ready = !side_we;
  assign side_rdata = rf[side_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (side_we) begin
      rf[side_addr] <= side_wdata;
    end else if (wr_en) begin
      rf[rd_i] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      not_claimed <= 1'b0;
      rsvd_flag <= 1'b0;
    end else begin
      done <= accept;
      not_claimed <= accept && !claimed;
      rsvd_flag <= accept && claimed && !legal;
    end
  end

  assert_done_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> done);
  assert_done_only_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !done);
  assert_ready_vs_side_R8: assert property (@(posedge clk) disable iff (!rst_n)
    side_we |-> !insn_ready);
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(not_claimed && rsvd_flag));
  assert_flag_needs_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (not_claimed || rsvd_flag) |-> done);
  assert_no_write_unclaimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !claimed && side_addr == rd_i) |=> $stable(side_rdata));
endmodule

// File: tb/pcmove_unit_tb_top.sv
module pcmove_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_valid = 1'b0;
  logic insn_ready;
  logic [31:0] insn_word = '0;
  logic done, not_claimed, rsvd_flag;
  logic side_we = 1'b0;
  logic [3:0] side_addr = '0;
  logic [31:0] side_wdata = '0;
  logic [31:0] side_rdata;

  int total = 0;
  int bad = 0;
  logic [31:0] model [16];

  always #2.5 clk = ~clk;

  pcmove_unit dut_i (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn_word(insn_word), .done(done), .not_claimed(not_claimed), .rsvd_flag(rsvd_flag),
    .side_we(side_we), .side_addr(side_addr), .side_wdata(side_wdata), .side_rdata(side_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int sub, input int rs, input int rc, input int rd);
    return {11'd0, 3'(sub), 4'(rs), 4'(rc), 4'(rd), 6'h39};
  endfunction

  function automatic logic [31:0] expect_move(input int sub, input logic [31:0] c,
                                               input logic [31:0] s, input logic [31:0] d);
    int w;
    logic [31:0] r;
    w = (sub < 2) ? 8 : (sub < 4) ? 16 : 32;
    r = d;
    for (int lo = 0; lo < 32; lo += w) begin
      logic [31:0] cl;
      logic is_zero;
      cl = (c >> lo) & ((w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1));
      is_zero = (cl == 0);
      if ((sub % 2 == 0) ? is_zero : !is_zero)
        for (int b = lo; b < lo + w; b++) r[b] = s[b];
    end
    return r;
  endfunction

  task automatic poke(input int a, input logic [31:0] v);
    @(negedge clk);
    side_we = 1'b1; side_addr = 4'(a); side_wdata = v;
    #1 chk("R8 ready low during side write", 32'(insn_ready), 32'd0);
    @(negedge clk);
    side_we = 1'b0;
    model[a] = v;
  endtask

  task automatic peek(input int a, output logic [31:0] v);
    @(negedge clk);
    side_addr = 4'(a);
    #1 v = side_rdata;
  endtask

  task automatic verify_all(input string req);
    logic [31:0] v;
    int mism = 0;
    logic [31:0] first_act = '0, first_exp = '0;
    for (int i = 0; i < 16; i++) begin
      peek(i, v);
      if (v !== model[i] && mism == 0) begin first_act = v; first_exp = model[i]; end
      if (v !== model[i]) mism++;
    end
    chk(req, (mism == 0) ? 32'd0 : first_act, (mism == 0) ? 32'd0 : first_exp);
  endtask

  task automatic issue(input logic [31:0] w, input logic exp_nc, input logic exp_rs,
                       input string req);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w;
    @(negedge clk);
    insn_valid = 1'b0;
    chk({req, " done"}, 32'(done), 32'd1);
    chk({req, " not_claimed"}, 32'(not_claimed), 32'(exp_nc));
    chk({req, " rsvd_flag"}, 32'(rsvd_flag), 32'(exp_rs));
    @(negedge clk);
    chk("R8 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic do_move(input int sub, input int rs, input int rc, input int rd, input string req);
    logic [31:0] e;
    e = expect_move(sub, model[rc], model[rs], model[rd]);
    issue(enc(sub, rs, rc, rd), 1'b0, 1'b0, req);
    model[rd] = e;
    verify_all(req);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) model[i] = '0;
    verify_all("R9 reset clears registers");
    chk("R8 idle done low", 32'(done), 32'd0);
    chk("R8 ready high idle", 32'(insn_ready), 32'd1);
  endtask

  task automatic t_side;
    logic [31:0] v;
    poke(9, 32'hCAFE_F00D);
    peek(9, v);
    chk("R9 side readback", v, 32'hCAFE_F00D);
  endtask

  task automatic t_bytes;
    poke(1, 32'h00FF_0012);
    poke(2, 32'hA1B2_C3D4);
    poke(3, 32'h1122_3344);
    do_move(0, 2, 1, 3, "R3 byte if-zero");
    chk("R3 byte if-zero value", model[3], 32'hA122_C344);
    poke(3, 32'h1122_3344);
    do_move(1, 2, 1, 3, "R3 byte if-nonzero");
    chk("R3 byte if-nonzero value", model[3], 32'h11B2_33D4);
  endtask

  task automatic t_halves;
    poke(4, 32'h0000_0100);
    poke(5, 32'h5555_6666);
    poke(6, 32'h7777_8888);
    do_move(2, 5, 4, 6, "R4 half if-zero");
    chk("R4 half if-zero value", model[6], 32'h5555_8888);
    poke(6, 32'h7777_8888);
    do_move(3, 5, 4, 6, "R4 half if-nonzero");
    chk("R4 half if-nonzero value", model[6], 32'h7777_6666);
  endtask

  task automatic t_word;
    poke(7, 32'h0000_0000);
    poke(8, 32'h8000_0000);
    poke(10, 32'hDEAD_BEEF);
    poke(11, 32'h0123_4567);
    do_move(4, 10, 7, 11, "R5 word if-zero taken");
    chk("R5 word taken value", model[11], 32'hDEAD_BEEF);
    poke(11, 32'h0123_4567);
    do_move(4, 10, 8, 11, "R5 word if-zero kept");
    chk("R5 word kept value", model[11], 32'h0123_4567);
    do_move(5, 10, 8, 11, "R5 word if-nonzero taken");
    chk("R5 nonzero value", model[11], 32'hDEAD_BEEF);
  endtask

  task automatic t_fields;
    poke(12, 32'h0000_FF00);
    poke(13, 32'h9999_AAAA);
    poke(14, 32'hBBBB_CCCC);
    do_move(1, 13, 12, 14, "R6 field decode high indices");
    chk("R6 value", model[14], 32'hBBBB_AACC);
  endtask

  task automatic t_alias;
    poke(15, 32'h00AB_00CD);
    poke(0, 32'h1111_2222);
    do_move(0, 0, 15, 15, "R7 cond equals dst");
    chk("R7 value", model[15], 32'h11AB_22CD);
  endtask

  task automatic t_unclaimed;
    poke(3, 32'h0000_0000);
    poke(2, 32'hFFFF_FFFF);
    issue({enc(4, 2, 3, 3)} ^ 32'h1, 1'b1, 1'b0, "R1 unclaimed");
    verify_all("R1 unclaimed no change");
  endtask

  task automatic t_reserved;
    issue(enc(6, 2, 3, 3), 1'b0, 1'b1, "R2 reserved 6");
    issue(enc(7, 2, 3, 3), 1'b0, 1'b1, "R2 reserved 7");
    verify_all("R2 reserved no change");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_side();
    t_bytes();
    t_halves();
    t_word();
    t_fields();
    t_alias();
    t_unclaimed();
    t_reserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule